// File: doc/BRIEF.md
# Single-Level Page-Table Address Translator

This block turns a virtual address into a physical address by fetching one entry from a page table that lives in physical memory. The physical page that holds the current table is given by a table-base input. The processor's privilege level is given by a kernel-mode input. Each accepted request causes at most one entry read over a synchronous read port. The block then returns either a physical address or a fault with a two-bit cause.

The request port uses a valid/ready handshake, and only one translation can be in flight at a time. The request address, the mode and the table base are all captured when the request is accepted. A virtual address with any bit set above the valid range faults at once, and no table read is made for it. The block has no write path, so a translation never alters memory.

Top module: `ptx_xlate`

## Requirements
- R1: While reset is held and just after it is released, `req_ready` is 1, and `rsp_valid` and `mem_rd_en` are 0.
- R2: A request with any `req_vaddr` bit set at or above position VA_W (16) gives `rsp_valid` in the cycle after acceptance. The response has `rsp_fault`=1 and `rsp_cause`=1. No memory read is issued for it.
- R3: An in-range request issues exactly one read, with `mem_rd_en` high in the cycle after acceptance. The read address is table base × 2^OFF_W + index, where the index is `req_vaddr[15:12]` and OFF_W is 12.
- R4: An entry whose present bit (bit 15) is 0 gives a fault with `rsp_cause`=2.
- R5: A present entry whose user-allowed bit (bit 14) is 0 is a kernel-only page. It faults with `rsp_cause`=3 in user mode and is granted in kernel mode. When bit 14 is 1, the page is granted in both modes.
- R6: A granted entry gives `rsp_fault`=0 and `rsp_cause`=0. The physical address is entry bits [7:0] × 2^12 + `req_vaddr[11:0]`, and `rsp_valid` rises in the third cycle after acceptance.
- R7: Once `rsp_valid` is high, it stays high with unchanged response fields until `rsp_ready` is seen. `req_ready` stays low while a request is outstanding, and both return to the idle values one cycle after the response is taken.
- R8: Changing `cur_tbl_ppn` or `kernel_mode` after a request has been accepted has no effect on that translation.
- R9: When the present bit is 0, cause 2 is reported even if the privilege check would also fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_tbl_ppn | input | 8 | Physical page number of the current page table |
| kernel_mode | input | 1 | 1 when the processor runs privileged |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 20 | Virtual address; bits 19:16 must be zero |
| mem_rd_en | output | 1 | Entry read strobe |
| mem_rd_addr | output | 20 | Entry word address |
| mem_rd_data | input | 16 | Entry word, valid one cycle after the strobe |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_fault | output | 1 | 1 = fault, 0 = physical address valid |
| rsp_cause | output | 2 | 0 none, 1 out of range, 2 not present, 3 privilege |
| rsp_paddr | output | 20 | Translated physical address |

## Verification
The acceptance edge is the reference point for all timing. An out-of-range fault is due one cycle after that edge. For a walk, the read strobe is due one cycle after it and the response two cycles later. The bench samples at the falling edge and counts falling edges from acceptance up to `rsp_valid`, so any extra or missing register stage shows up as a latency mismatch rather than going unseen. A read counter in the memory model confirms that each walk makes one read and that each range fault makes none. Response stability is checked on every stalled cycle.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_RANGE  = 2'd1,
    CAUSE_ABSENT = 2'd2,
    CAUSE_PRIV   = 2'd3
  } cause_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_CHECK = 2'd2,
    ST_RESP  = 2'd3
  } walk_st_t;
endpackage

// File: rtl/ptx_req_reg.sv
module ptx_req_reg #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 12,
  parameter int PPN_W = 8,
  localparam int IDX_W = VA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [VA_W-1:0]  vaddr_in,
  input  logic             kmode_in,
  input  logic [PPN_W-1:0] tbl_in,
  output logic [IDX_W-1:0] idx,
  output logic [OFF_W-1:0] off,
  output logic             kmode,
  output logic [PPN_W-1:0] tbl
);
  function automatic logic [IDX_W-1:0] va_index(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] va_offset(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      off   <= '0;
      kmode <= 1'b0;
      tbl   <= '0;
    end else if (accept) begin
      idx   <= va_index(vaddr_in);
      off   <= va_offset(vaddr_in);
      kmode <= kmode_in;
      tbl   <= tbl_in;
    end
  end
endmodule

// File: rtl/ptx_entry_check.sv
module ptx_entry_check
  import ptx_pkg::*;
#(
  parameter int PTE_W    = 16,
  parameter int PPN_W    = 8,
  parameter int OFF_W    = 12,
  parameter int PRES_BIT = 15,
  parameter int USER_BIT = 14,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             kmode,
  input  logic [OFF_W-1:0] off,
  output logic             fault,
  output logic [1:0]       cause,
  output logic [PA_W-1:0]  paddr
);
  function automatic logic [PA_W-1:0] form_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [OFF_W-1:0] o);
    return (PA_W'(ppn) << OFF_W) | PA_W'(o);
  endfunction

  logic [PTE_W-1:0] unused_pte_bits;
  assign unused_pte_bits = pte;

  cause_t verdict;

  always_comb begin
    if (!pte[PRES_BIT])                  verdict = CAUSE_ABSENT;
    else if (!(kmode || pte[USER_BIT]))  verdict = CAUSE_PRIV;
    else                                 verdict = CAUSE_NONE;
  end

  assign cause = verdict;
  assign fault = (verdict != CAUSE_NONE);
  assign paddr = form_pa(pte[PPN_W-1:0], off);
endmodule

// File: rtl/ptx_walk_ctrl.sv
module ptx_walk_ctrl
  import ptx_pkg::*;
#(
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            oor_now,
  input  logic            rsp_ready,
  input  logic            chk_fault,
  input  logic [1:0]      chk_cause,
  input  logic [PA_W-1:0] chk_paddr,
  output logic            req_ready,
  output logic            accept,
  output logic            mem_rd_en,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [1:0]      rsp_cause,
  output logic [PA_W-1:0] rsp_paddr
);
  walk_st_t st;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_rd_en = (st == ST_READ);
  assign rsp_valid = (st == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_NONE;
      rsp_paddr <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          if (oor_now) begin
            rsp_fault <= 1'b1;
            rsp_cause <= CAUSE_RANGE;
            rsp_paddr <= '0;
            st        <= ST_RESP;
          end else begin
            st <= ST_READ;
          end
        end
        ST_READ:  st <= ST_CHECK;
        ST_CHECK: begin
          rsp_fault <= chk_fault;
          rsp_cause <= chk_cause;
          rsp_paddr <= chk_paddr;
          st        <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptx_xlate.sv
module ptx_xlate #(
  parameter int REQ_VA_W = 20,
  parameter int VA_W     = 16,
  parameter int OFF_W    = 12,
  parameter int PPN_W    = 8,
  parameter int PTE_W    = 16,
  parameter int PRES_BIT = 15,
  parameter int USER_BIT = 14,
  localparam int IDX_W = VA_W - OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PPN_W-1:0]    cur_tbl_ppn,
  input  logic                kernel_mode,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [REQ_VA_W-1:0] req_vaddr,
  output logic                mem_rd_en,
  output logic [PA_W-1:0]     mem_rd_addr,
  input  logic [PTE_W-1:0]    mem_rd_data,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_fault,
  output logic [1:0]          rsp_cause,
  output logic [PA_W-1:0]     rsp_paddr
);
  function automatic logic [PA_W-1:0] entry_addr(input logic [PPN_W-1:0] base,
                                                 input logic [IDX_W-1:0] ix);
    return (PA_W'(base) << OFF_W) + PA_W'(ix);
  endfunction

  logic             evt_accept;
  logic             evt_range_fault;
  logic [IDX_W-1:0] cap_idx;
  logic [OFF_W-1:0] cap_off;
  logic             cap_kmode;
  logic [PPN_W-1:0] cap_tbl;
  logic             chk_fault;
  logic [1:0]       chk_cause;
  logic [PA_W-1:0]  chk_paddr;

  generate
    if (REQ_VA_W > VA_W) begin : g_range
      assign evt_range_fault = |req_vaddr[REQ_VA_W-1:VA_W];
    end else begin : g_norange
      assign evt_range_fault = 1'b0;
    end
  endgenerate

  ptx_req_reg #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_req (
    .clk(clk), .rst_n(rst_n), .accept(evt_accept),
    .vaddr_in(req_vaddr[VA_W-1:0]), .kmode_in(kernel_mode), .tbl_in(cur_tbl_ppn),
    .idx(cap_idx), .off(cap_off), .kmode(cap_kmode), .tbl(cap_tbl)
  );

  assign mem_rd_addr = entry_addr(cap_tbl, cap_idx);

  ptx_entry_check #(.PTE_W(PTE_W), .PPN_W(PPN_W), .OFF_W(OFF_W),
                    .PRES_BIT(PRES_BIT), .USER_BIT(USER_BIT)) u_chk_logic (
    .pte(mem_rd_data), .kmode(cap_kmode), .off(cap_off),
    .fault(chk_fault), .cause(chk_cause), .paddr(chk_paddr)
  );

  ptx_walk_ctrl #(.PA_W(PA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .oor_now(evt_range_fault),
    .rsp_ready(rsp_ready), .chk_fault(chk_fault), .chk_cause(chk_cause),
    .chk_paddr(chk_paddr), .req_ready(req_ready), .accept(evt_accept),
    .mem_rd_en(mem_rd_en), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );
endmodule

// File: rtl/ptx_xlate_chk.sv
module ptx_xlate_chk #(
  parameter int REQ_VA_W = 20,
  parameter int VA_W     = 16,
  parameter int PA_W     = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [REQ_VA_W-1:0] req_vaddr,
  input logic                evt_accept,
  input logic                mem_rd_en,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic                rsp_fault,
  input logic [1:0]          rsp_cause,
  input logic [PA_W-1:0]     rsp_paddr
);
  logic in_range;
  assign in_range = ((req_vaddr >> VA_W) == '0);

  // R2: out-of-range request faults next cycle without a read
  a_r2_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !in_range) |=>
      (rsp_valid && rsp_fault && rsp_cause == 2'd1 && !mem_rd_en));

  // R3: in-range request reads the table in the next cycle
  a_r3_read_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && in_range) |=> (mem_rd_en && !rsp_valid));

  // R6: a non-fault response carries cause zero
  a_r6_ok_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0));

  // R7: stalled response holds its fields
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_fault) && $stable(rsp_cause) && $stable(rsp_paddr)));

  // R7: no new request while one is outstanding
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rd_en) |-> !req_ready);
endmodule

bind ptx_xlate ptx_xlate_chk #(.REQ_VA_W(REQ_VA_W), .VA_W(VA_W), .PA_W(PA_W)) u_xlate_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .evt_accept(evt_accept), .mem_rd_en(mem_rd_en),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
  .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
);

// File: tb/ptx_xlate_tb.sv
module ptx_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cur_tbl_ppn = 8'h35;
  logic        kernel_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vaddr = '0;
  logic        mem_rd_en;
  logic [19:0] mem_rd_addr;
  logic [15:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic [19:0] rsp_paddr;

  int checks = 0;
  int failures = 0;
  int rd_cnt = 0;
  logic [19:0] last_rd_addr = '0;
  logic [15:0] tbl [16];

  always #10 clk = ~clk;

  ptx_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cur_tbl_ppn(cur_tbl_ppn), .kernel_mode(kernel_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );

  // memory model: table page 0x35, words 0..15
  always @(posedge clk) begin
    if (mem_rd_en) begin
      rd_cnt <= rd_cnt + 1;
      last_rd_addr <= mem_rd_addr;
      if (mem_rd_addr[19:12] == 8'h35 && mem_rd_addr[11:4] == 8'h00)
        mem_rd_data <= tbl[mem_rd_addr[3:0]];
      else
        mem_rd_data <= 16'h0000;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // {vaddr, kmode, exp_fault, exp_cause, exp_paddr}
  localparam logic [43:0] VECS [9] = '{
    {20'h00123, 1'b0, 1'b0, 2'd0, 20'hA1123},
    {20'h01ABC, 1'b1, 1'b0, 2'd0, 20'h42ABC},
    {20'h01ABC, 1'b0, 1'b1, 2'd3, 20'h00000},
    {20'h02000, 1'b1, 1'b1, 2'd2, 20'h00000},
    {20'h0FFFF, 1'b0, 1'b0, 2'd0, 20'hFFFFF},
    {20'h10000, 1'b1, 1'b1, 2'd1, 20'h00000},
    {20'h80123, 1'b0, 1'b1, 2'd1, 20'h00000},
    {20'h00000, 1'b1, 1'b0, 2'd0, 20'hA1000},
    {20'h0F001, 1'b1, 1'b0, 2'd0, 20'hFF001}
  };

  task automatic xlate(input logic [19:0] va, input logic km, input logic ef,
                       input logic [1:0] ec, input logic [19:0] epa, input string rq,
                       input int hold, input bit disturb);
    int n;
    int rd0;
    int exp_lat;
    logic [19:0] held_pa;
    @(negedge clk);
    rd0 = rd_cnt;
    req_vaddr = va; kernel_mode = km; req_valid = 1'b1; rsp_ready = (hold == 0);
    chk(req_ready, rq, "ready before accept", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (disturb) begin cur_tbl_ppn = 8'h00; kernel_mode = ~km; end
    n = 1;
    while (!rsp_valid && n < 10) begin @(negedge clk); n++; end
    exp_lat = (ef && ec == 2'd1) ? 1 : 3;
    chk(n == exp_lat, rq, "latency", n, exp_lat);
    chk(rsp_fault == ef, rq, "fault flag", rsp_fault, ef);
    chk(rsp_cause == ec, rq, "cause", rsp_cause, ec);
    if (!ef) chk(rsp_paddr == epa, rq, "paddr", rsp_paddr, epa);
    if (ef && ec == 2'd1) begin
      chk(rd_cnt == rd0, "R2", "reads on range fault", rd_cnt - rd0, 0);
    end else begin
      chk(rd_cnt == rd0 + 1, "R3", "read count", rd_cnt - rd0, 1);
      chk(last_rd_addr == {8'h35, 8'h00, va[15:12]}, "R3", "entry address",
          last_rd_addr, {8'h35, 8'h00, va[15:12]});
    end
    held_pa = rsp_paddr;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_paddr == held_pa && rsp_cause == ec,
          "R7", "stalled response", {rsp_valid, req_ready, rsp_paddr}, {1'b1, 1'b0, held_pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R7", "release after take", {rsp_valid, req_ready}, 2'b01);
    rsp_ready = 1'b0;
    cur_tbl_ppn = 8'h35;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) tbl[i] = 16'h0000;
    tbl[0]  = 16'hC0A1;  // present, user allowed
    tbl[1]  = 16'h8042;  // present, kernel only
    tbl[2]  = 16'h4077;  // absent
    tbl[3]  = 16'h0013;  // absent, kernel only
    tbl[15] = 16'hC0FF;

    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_en, "R1", "in reset",
        {req_ready, rsp_valid, mem_rd_en}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_en, "R1", "after reset",
        {req_ready, rsp_valid, mem_rd_en}, 3'b100);

    for (int v = 0; v < 9; v++) begin
      string tag;
      if (!VECS[v][22]) tag = "R6";
      else if (VECS[v][21:20] == 2'd1) tag = "R2";
      else if (VECS[v][21:20] == 2'd2) tag = "R4";
      else tag = "R5";
      xlate(VECS[v][43:24], VECS[v][23], VECS[v][22], VECS[v][21:20], VECS[v][19:0],
            tag, 0, 1'b0);
    end

    // R5: kernel-only page granted in kernel mode, user page in kernel mode
    xlate(20'h01005, 1'b1, 1'b0, 2'd0, 20'h42005, "R5", 0, 1'b0);
    xlate(20'h00FFF, 1'b1, 1'b0, 2'd0, 20'hA1FFF, "R5", 0, 1'b0);
    // R9: absent and kernel-only in user mode reports absent
    xlate(20'h03456, 1'b0, 1'b1, 2'd2, 20'h00000, "R9", 0, 1'b0);
    // R7: response stalled for several cycles, walk and range fault
    xlate(20'h00777, 1'b0, 1'b0, 2'd0, 20'hA1777, "R7", 4, 1'b0);
    xlate(20'h40000, 1'b0, 1'b1, 2'd1, 20'h00000, "R7", 3, 1'b0);
    // R8: base and mode change after acceptance are ignored
    xlate(20'h01ABC, 1'b1, 1'b0, 2'd0, 20'h42ABC, "R8", 0, 1'b1);
    xlate(20'h01ABC, 1'b0, 1'b1, 2'd3, 20'h00000, "R8", 0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule